// File: doc/BRIEF.md
# Power-Fail Write Gate with Battery Flag

This block sits between a memory bus and a static memory array. It watches three digitized supply-status signals: supply above the deselect threshold, supply below the battery switchover threshold, and a battery-weak comparator result. It forces the array's chip select, output enable and write strobe inactive while the supply is out of tolerance. When power returns, it holds that protection for a set recovery time. It drives a battery-select output that follows the switchover comparator.

The battery-weak result is captured as the supply comes back. If it shows a weak battery, a flag is set. While the flag is up, the first write that reaches the block is swallowed. The flag then drops by itself, so software can detect a weak battery by writing a complement and reading it back. The three status inputs are asynchronous, and each passes through a two-flop synchronizer. Bus strobes are active low and are assumed synchronous to `clk`.

Top module: `pwrfail_wgate`

## Requirements
- R1: While `rst_n` is low and just after it is released, `wr_protect`=1, `batt_flag`=0, `bat_sel`=0, and `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1.
- R2: While `wr_protect`=1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` stay 1 whatever the bus strobes do.
- R3: When `supply_good` rises and stays high, `wr_protect` falls at the (RECOVERY_CYCLES+3)-th rising clock edge that samples it high.
- R4: When `supply_good` falls, `wr_protect` is 1 after the 3rd rising edge that samples it low.
- R5: `bat_sel` equals the level of `supply_low` sampled 3 rising edges earlier.
- R6: On leaving the power-fail state (the 3rd edge sampling `supply_good` high), `batt_flag` loads the synchronized `batt_weak` level. It is not changed otherwise, except by R7.
- R7: While `batt_flag`=1 and the block is unprotected, `mem_we_n` stays 1. A write attempt (`bus_ce_n`=0 and `bus_we_n`=0) clears the flag at the first rising edge where the attempt is no longer present.
- R8: A drop of `supply_good` during recovery restarts it, so the full R3 delay counts from the final rise.
- R9: When unprotected with `batt_flag`=0, each of `mem_ce_n`, `mem_oe_n` and `mem_we_n` equals its bus strobe in the same cycle.
- R10: A read (`bus_we_n`=1) with `batt_flag`=1 passes `bus_ce_n` and `bus_oe_n` through and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good | input | 1 | Supply above deselect threshold (async) |
| supply_low | input | 1 | Supply below battery switchover threshold (async) |
| batt_weak | input | 1 | Battery-weak comparator result (async) |
| bus_ce_n | input | 1 | Bus chip select, active low |
| bus_we_n | input | 1 | Bus write strobe, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| mem_ce_n | output | 1 | Array chip select, active low |
| mem_we_n | output | 1 | Array write strobe, active low |
| mem_oe_n | output | 1 | Array output enable, active low |
| bat_sel | output | 1 | Select battery as array supply |
| wr_protect | output | 1 | Deselect/write protection active |
| batt_flag | output | 1 | Battery-weak flag |

## Verification
The bench builds the block with RECOVERY_CYCLES=12 in place of the multi-million default. This puts whole recovery windows, restarted recoveries and several power cycles within a few hundred clocks. At that size, the exact release edge after the synchronizer latency can be counted directly. The weak-battery power-up and the good-battery power-up can both be run back to back.

// File: rtl/pwrfail_wgate.sv
module pwrfail_wgate #(
  parameter int RECOVERY_CYCLES = 8000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_good,
  input  logic supply_low,
  input  logic batt_weak,
  input  logic bus_ce_n,
  input  logic bus_we_n,
  input  logic bus_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic bat_sel,
  output logic wr_protect,
  output logic batt_flag
);
  localparam int CW = (RECOVERY_CYCLES < 2) ? 1 : $clog2(RECOVERY_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(RECOVERY_CYCLES - 1);

  typedef enum logic [1:0] {PF_HOLD, PF_RECOVER, PF_RUN} pf_state_t;

  pf_state_t state;
  logic [CW-1:0] cnt;
  logic [1:0] ok_sync, low_sync, weak_sync;
  logic ok_s, low_s, weak_s;
  logic wr_try, wr_try_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ok_sync   <= '0;
      low_sync  <= '0;
      weak_sync <= '0;
    end else begin
      ok_sync   <= {ok_sync[0], supply_good};
      low_sync  <= {low_sync[0], supply_low};
      weak_sync <= {weak_sync[0], batt_weak};
    end

  assign ok_s   = ok_sync[1];
  assign low_s  = low_sync[1];
  assign weak_s = weak_sync[1];

  assign wr_protect = (state != PF_RUN);
  assign wr_try     = !bus_ce_n && !bus_we_n && !wr_protect;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= PF_HOLD;
      cnt       <= '0;
      batt_flag <= 1'b0;
      wr_try_q  <= 1'b0;
      bat_sel   <= 1'b0;
    end else begin
      bat_sel  <= low_s;
      wr_try_q <= wr_try;
      if (!ok_s) begin
        state <= PF_HOLD;
        cnt   <= '0;
      end else begin
        case (state)
          PF_HOLD: begin
            state     <= PF_RECOVER;
            cnt       <= '0;
            batt_flag <= weak_s;
          end
          PF_RECOVER:
            if (cnt == LAST) state <= PF_RUN;
            else cnt <= cnt + 1'b1;
          default:
            if (batt_flag && wr_try_q && !wr_try) batt_flag <= 1'b0;
        endcase
      end
    end

  assign mem_ce_n = bus_ce_n | wr_protect;
  assign mem_oe_n = bus_oe_n | wr_protect;
  assign mem_we_n = bus_we_n | wr_protect | batt_flag;
endmodule

// File: rtl/pwrfail_wgate_chk.sv
module pwrfail_wgate_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_protect,
  input logic batt_flag,
  input logic bat_sel,
  input logic mem_ce_n,
  input logic mem_we_n,
  input logic mem_oe_n,
  input logic ok_s,
  input logic low_s
);
  // R2
  held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |-> (mem_ce_n && mem_oe_n && mem_we_n));
  // R7
  flag_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batt_flag |-> mem_we_n);
  // R4
  fail_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_s |=> wr_protect);
  // R3
  release_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_protect) |-> $past(ok_s));
  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(batt_flag) |-> $past(wr_protect));
  // R5
  batsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel == $past(low_s));
endmodule

bind pwrfail_wgate pwrfail_wgate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_protect(wr_protect), .batt_flag(batt_flag),
  .bat_sel(bat_sel), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .ok_s(ok_s), .low_s(low_s)
);

// File: tb/pwrfail_wgate_tb.sv
`timescale 1ns/100ps
module pwrfail_wgate_tb;
  localparam int REC = 12;

  logic clk = 0, rst_n = 0;
  logic supply_good = 0, supply_low = 1, batt_weak = 0;
  logic bus_ce_n = 1, bus_we_n = 1, bus_oe_n = 1;
  logic mem_ce_n, mem_we_n, mem_oe_n, bat_sel, wr_protect, batt_flag;

  int checks = 0, failures = 0;
  bit cmp_en = 0, done = 0;

  pwrfail_wgate #(.RECOVERY_CYCLES(REC)) u_dut (.*);

  always #2.5 clk = ~clk;

  // behavioural reference model
  bit m_ok1, m_ok2, m_low1, m_low2, m_wk1, m_wk2, m_flag, m_bat, m_attq;
  int m_run;
  always @(posedge clk) begin
    bit prot, att;
    if (!rst_n) begin
      {m_ok1, m_ok2, m_low1, m_low2, m_wk1, m_wk2, m_flag, m_bat, m_attq} = '0;
      m_run = 0;
    end else begin
      prot = (m_run < REC + 1);
      att  = !bus_ce_n && !bus_we_n && !prot;
      if (!m_ok2) m_run = 0;
      else begin
        if (m_run == 0) m_flag = m_wk2;
        else if (!prot && m_flag && m_attq && !att) m_flag = 0;
        if (m_run < REC + 1) m_run++;
      end
      m_attq = att;
      m_bat  = m_low2;
      m_ok2 = m_ok1;  m_ok1 = supply_good;
      m_low2 = m_low1; m_low1 = supply_low;
      m_wk2 = m_wk1;  m_wk1 = batt_weak;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en && !done) begin
    bit p;
    p = (m_run < REC + 1);
    chk("R3/R4 wr_protect", wr_protect, p);
    chk("R6/R7 batt_flag", batt_flag, m_flag);
    chk("R5 bat_sel", bat_sel, m_bat);
    chk("R2/R9 mem_ce_n", mem_ce_n, bus_ce_n | p);
    chk("R2/R9/R10 mem_oe_n", mem_oe_n, bus_oe_n | p);
    chk("R2/R7/R9 mem_we_n", mem_we_n, bus_we_n | p | m_flag);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic edges_until(input logic val, output int e);
    e = 0;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk); e++; #1;
      if (wr_protect == val) break;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int e;
    step(3);
    // R1 during reset
    chk("R1 protect", wr_protect, 1); chk("R1 flag", batt_flag, 0);
    chk("R1 bat_sel", bat_sel, 0);
    chk("R1 strobes", mem_ce_n & mem_we_n & mem_oe_n, 1);
    rst_n = 1; cmp_en = 1;
    step(1);
    chk("R1 after release", wr_protect, 1);
    step(2);
    // R5: switchover input drops, bat_sel follows 3 edges later
    supply_low = 0;
    step(2); chk("R5 still battery", bat_sel, 1);
    step(1); chk("R5 external power", bat_sel, 0);
    // power up with weak battery; R3 release timing, R2 strobes during recovery
    batt_weak = 1; supply_good = 1;
    bus_ce_n = 0; bus_we_n = 0; bus_oe_n = 0;
    edges_until(0, e);
    chk("R3 release edge", e == REC + 3, 1);
    bus_we_n = 1; bus_ce_n = 1; bus_oe_n = 1;
    step(1);
    chk("R6 flag set", batt_flag, 1);
    // R10 read with flag set
    bus_ce_n = 0; bus_oe_n = 0;
    step(1);
    chk("R10 ce pass", mem_ce_n, 0); chk("R10 oe pass", mem_oe_n, 0);
    bus_oe_n = 1;
    step(1); chk("R10 flag kept", batt_flag, 1);
    // R7 first write swallowed
    bus_we_n = 0;
    step(1); chk("R7 we blocked", mem_we_n, 1);
    step(1); chk("R7 still blocked", mem_we_n, 1); chk("R7 flag held", batt_flag, 1);
    bus_we_n = 1;
    step(1); chk("R7 flag cleared", batt_flag, 0);
    // R9 next write passes
    bus_we_n = 0;
    step(0); chk("R9 we pass", mem_we_n, 0); chk("R9 ce pass", mem_ce_n, 0);
    step(2);
    bus_we_n = 1; bus_ce_n = 1;
    step(1);
    // R4 power fail
    supply_good = 0;
    edges_until(1, e);
    chk("R4 protect edge", e == 3, 1);
    bus_ce_n = 0; bus_we_n = 0;
    step(2); chk("R2 ce held", mem_ce_n, 1); chk("R2 we held", mem_we_n, 1);
    bus_ce_n = 1; bus_we_n = 1;
    supply_low = 1; step(6);
    // R8 restart during recovery; battery good now
    batt_weak = 0; supply_low = 0; step(4);
    supply_good = 1; step(REC / 2 + 3);
    chk("R8 still protected", wr_protect, 1);
    supply_good = 0; step(1);
    supply_good = 1;
    edges_until(0, e);
    chk("R8 full delay after restart", e == REC + 3, 1);
    chk("R6 good battery flag", batt_flag, 0);
    bus_ce_n = 0; bus_we_n = 0;
    step(0); chk("R9 first write passes", mem_we_n, 0);
    step(2);
    bus_ce_n = 1; bus_we_n = 1;
    step(3);
    finish_run();
  end
endmodule